// File: doc/BRIEF.md
# Fixed-Latency Ping-Pong Tag Delay Line

This block delays a one-bit valid flag and a row identifier by a fixed number of clock cycles, `DELAY`. Whatever enters on a given cycle leaves exactly `DELAY` cycles later. The line advances on every cycle, including cycles that carry no request. A cycle with no request still takes a slot, and that slot holds a cleared valid flag. A downstream stage can therefore treat the output as the input seen through a deep pipeline of known length.

The storage is two single-port memory banks, not one dual-port array. Slots alternate between the two banks according to the low bit of the slot pointer. The slot being written and the slot being read are always neighbours, so in every cycle one bank takes the write while the other performs the read. The banks supply `DELAY-1` cycles of delay, and a final output register adds the last cycle.

The memories are never cleared. A warm-up counter keeps the output invalid until every slot being read has been written since the last reset.

Top module: `tag_delay_line`

## Requirements
- R1: After warm-up, `out_valid` and `out_id` in the cycle following clock edge n equal `in_valid` and `in_id` sampled at edge n-`DELAY`, for every pattern of inputs.
- R2: A cycle with `in_valid` low yields `out_valid` low exactly `DELAY` cycles later, even when the neighbouring cycles carry valid requests.
- R3: For the first `DELAY` clock edges after `rst_n` goes high, `out_valid` stays low, whatever the inputs are and whatever the memories held before the reset. While `rst_n` is low, `out_valid` is low.
- R4: Whenever `out_valid` is low, `out_id` is all zeros.
- R5: On every cycle out of reset, one bank is written and the other bank is read. The write and the read never target the same bank, so an unbroken stream of valid requests is delivered without loss.
- R6: The write slot pointer advances by one slot per cycle modulo `DELAY`. The read slot is always the slot that follows the write slot.
- R7: `DELAY` must be even and at least 4. `in_id` is `$clog2(ROWS)` bits wide, and elaboration is rejected for any other shape of `DELAY`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A request is present this cycle |
| in_id | input | ID_W | Row identifier of the request |
| out_valid | output | 1 | Delayed request flag |
| out_id | output | ID_W | Delayed row identifier; zero when `out_valid` is low |

## Verification
In every cycle the line both stores the current entry and retires the entry from `DELAY` cycles earlier, and these two accesses must land in opposite banks. The bench provokes this with unbroken runs of valid requests, runs that alternate valid and idle cycles, and long pseudo-random runs. At each cycle it compares the output with its own history of the inputs, shifted by exactly `DELAY`. The second overlap is warm-up against stale contents: a reset in the middle of traffic leaves valid entries in the banks, and the bench judges that none of them appear at the output during the first `DELAY` cycles after the reset is released.

// File: rtl/tag_delay_pkg.sv
// Shared helpers for the tag delay line.
// Assumes slot counts are small enough to fit in an int.
package tag_delay_pkg;

    // Returns the slot index that follows 'cur' in a ring of 'len' slots.
    function automatic int unsigned ring_next(int unsigned cur, int unsigned len);
        return (cur == len - 1) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/tag_slot_ptr.sv
// Slot pointer pair for the tag delay line.
// Keeps a write slot and a read slot that always sits one slot ahead of it,
// both stepping once per cycle around a ring of SLOTS entries.
// Assumes SLOTS is at least 2 and that rst_n is synchronous and active low.
module tag_slot_ptr
    import tag_delay_pkg::*;
#(
    parameter int unsigned SLOTS = 16,
    localparam int unsigned PW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] wr_slot,
    output logic [PW-1:0] rd_slot
);

    // Step both pointers each cycle; the read pointer starts one slot ahead.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_slot <= '0;
            rd_slot <= PW'(1);
        end else begin
            wr_slot <= PW'(ring_next(32'(wr_slot), SLOTS));
            rd_slot <= PW'(ring_next(32'(rd_slot), SLOTS));
        end
    end

endmodule

// File: rtl/tag_bank.sv
// Single-port storage bank with one read-write port.
// A write stores wdata at addr. A read puts the word into rdata at the clock edge.
// There is no reset, as in a plain SRAM macro; contents start unknown.
module tag_bank #(
    parameter int unsigned WORDS = 8,
    parameter int unsigned WIDTH = 4,
    localparam int unsigned AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [WORDS];

    // Single port: either store the word or register the addressed word.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end

endmodule

// File: rtl/tag_delay_line.sv
// Fixed-latency delay line for a valid flag and a row identifier.
// Slot k of a ring of DELAY slots lives in bank k[0] at row k>>1. The write
// slot and the read slot are neighbours, so they always fall in different
// banks. The bank read adds one registered stage after DELAY-1 cycles of
// storage, and the output register adds one more, for DELAY cycles in total.
// A warm-up counter hides slots that have not been written since reset.
// Assumes DELAY is even and at least 4, and a synchronous active-low reset.
module tag_delay_line #(
    parameter int unsigned DELAY = 16,
    parameter int unsigned ROWS  = 32,
    localparam int unsigned ID_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int unsigned EW   = ID_W + 1,
    localparam int unsigned PW   = $clog2(DELAY),
    localparam int unsigned HALF = DELAY / 2,
    localparam int unsigned AW   = PW - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [ID_W-1:0] in_id,
    output logic            out_valid,
    output logic [ID_W-1:0] out_id
);

    // R7: reject ring lengths that would let read and write share a bank.
    generate
        if ((DELAY % 2) != 0 || DELAY < 4) begin : g_bad_delay
            $error("tag_delay_line: DELAY must be even and at least 4");
        end
    endgenerate

    logic [PW-1:0] wr_slot;
    logic [PW-1:0] rd_slot;
    logic          wr_bank;
    logic          rd_bank;
    logic [AW-1:0] wr_row;
    logic [AW-1:0] rd_row;
    logic [EW-1:0] entry_in;
    logic [EW-1:0] bank_q [2];
    logic [EW-1:0] picked;
    logic          rd_sel_q;
    logic          primed_q;
    logic [PW-1:0] warm_cnt;

    tag_slot_ptr #(.SLOTS(DELAY)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_slot (wr_slot),
        .rd_slot (rd_slot)
    );

    // Split each slot into a bank select and a row inside that bank.
    always_comb begin
        wr_bank = wr_slot[0];
        rd_bank = rd_slot[0];
        wr_row  = wr_slot[PW-1:1];
        rd_row  = rd_slot[PW-1:1];
    end

    // Idle cycles still occupy a slot, stored with the flag cleared.
    always_comb begin
        entry_in = {in_valid, in_valid ? in_id : ID_W'(0)};
    end

    // One bank per slot parity; the write bank writes and the other one reads.
    generate
        for (genvar b = 0; b < 2; b++) begin : g_bank
            logic          b_we;
            logic [AW-1:0] b_addr;

            // Pick this bank's role and address for the current cycle.
            always_comb begin
                b_we   = (wr_bank == b[0]);
                b_addr = b_we ? wr_row : rd_row;
            end

            tag_bank #(.WORDS(HALF), .WIDTH(EW)) u_bank (
                .clk   (clk),
                .en    (rst_n),
                .we    (b_we),
                .addr  (b_addr),
                .wdata (entry_in),
                .rdata (bank_q[b])
            );
        end
    endgenerate

    // Count edges since reset until the read slot has been written at least once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_cnt <= '0;
        end else if (warm_cnt != PW'(DELAY - 1)) begin
            warm_cnt <= warm_cnt + PW'(1);
        end
    end

    // Remember which bank was read and whether that read was trustworthy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sel_q <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            rd_sel_q <= rd_bank;
            primed_q <= (warm_cnt == PW'(DELAY - 1));
        end
    end

    // Select the word from the bank that performed the read.
    always_comb begin
        picked = rd_sel_q ? bank_q[1] : bank_q[0];
    end

    // Output register: the final cycle of delay, with the id zeroed when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_id    <= '0;
        end else if (primed_q && picked[EW-1]) begin
            out_valid <= 1'b1;
            out_id    <= picked[ID_W-1:0];
        end else begin
            out_valid <= 1'b0;
            out_id    <= '0;
        end
    end

endmodule

// File: rtl/tag_delay_line_chk.sv
// Property checker for tag_delay_line, attached to every instance by bind.
// It keeps its own count of edges since reset to judge the warm-up window.
module tag_delay_line_chk #(
    parameter int unsigned DELAY = 16,
    parameter int unsigned ID_W  = 5,
    parameter int unsigned PW    = 4,
    localparam int unsigned CW   = $clog2(DELAY + 2) + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            out_valid,
    input logic [ID_W-1:0] out_id,
    input logic            wr_bank,
    input logic            rd_bank,
    input logic [PW-1:0]   wr_slot
);

    logic [CW-1:0] since_rst;
    logic          run_q;

    // Independent count of edges since reset, saturating just past DELAY.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst <= CW'(DELAY)) begin
            since_rst <= since_rst + CW'(1);
        end
    end

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        run_q <= rst_n;
    end

    // R3
    warmup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (since_rst > CW'(DELAY)));

    // R4
    idle_id_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_id == '0));

    // R5
    bank_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bank != rd_bank);

    // R6
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (wr_slot == (($past(wr_slot) == PW'(DELAY - 1)) ? PW'(0)
                                                                  : $past(wr_slot) + PW'(1))));

endmodule

bind tag_delay_line tag_delay_line_chk #(
    .DELAY (DELAY),
    .ID_W  (ID_W),
    .PW    (PW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_id    (out_id),
    .wr_bank   (wr_bank),
    .rd_bank   (rd_bank),
    .wr_slot   (wr_slot)
);

// File: tb/tag_delay_line_test.sv
// Self-checking bench: drives sweeps and pseudo-random streams into a small
// instance and compares each output with its own record of the inputs.
module tag_delay_line_test;

    localparam int unsigned D    = 6;
    localparam int unsigned ROWS = 8;
    localparam int unsigned IW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [IW-1:0] in_id = '0;
    logic          out_valid;
    logic [IW-1:0] out_id;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int edges = 0;
    bit done = 1'b0;
    logic          hv [4096];
    logic [IW-1:0] hid [4096];
    logic [15:0]   lfsr = 16'hACE1;

    tag_delay_line #(.DELAY(D), .ROWS(ROWS)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_id     (in_id),
        .out_valid (out_valid),
        .out_id    (out_id)
    );

    always #5 clk = ~clk;

    // Counts clock edges for the watchdog.
    always @(posedge clk) edges <= edges + 1;

    // Compares the output with the expected flag and id.
    task automatic check(input logic ev, input logic [IW-1:0] eid, input string req);
        checks++;
        if (out_valid !== ev || out_id !== (ev ? eid : '0)) begin
            failures++;
            $display("FAIL %s cyc=%0d actual valid=%0b id=%0d expected valid=%0b id=%0d",
                     req, cyc, out_valid, out_id, ev, ev ? eid : '0);
        end
    endtask

    // Drives one input cycle, then checks the output after that edge.
    task automatic step(input logic v, input logic [IW-1:0] id, input string req);
        in_valid = v;
        in_id    = id;
        hv[cyc]  = v;
        hid[cyc] = id;
        @(posedge clk);
        @(negedge clk);
        if (cyc >= D) check(hv[cyc - D], hid[cyc - D], req);
        else          check(1'b0, '0, "R3");
        cyc++;
    endtask

    // Holds reset for a few cycles with valid traffic on the inputs; R3 reset state.
    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            in_valid = 1'b1;
            in_id    = IW'(i + 5);
            @(posedge clk);
            @(negedge clk);
            check(1'b0, '0, "R3");
        end
        rst_n = 1'b1;
        cyc = 0;
    endtask

    // Advances the pseudo-random source.
    task automatic lfsr_step();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1 R5: unbroken run of valid requests over every id, twice.
        for (int r = 0; r < 2; r++)
            for (int i = 0; i < ROWS; i++) step(1'b1, IW'(i), "R5");
        // R2 R4: alternating valid and idle cycles, then idle pairs.
        for (int i = 0; i < 16; i++) step(i[0], IW'(7 - (i % 8)), "R2");
        for (int i = 0; i < 12; i++) step((i % 3) == 0, IW'(i), "R4");
        // R1 R6: pseudo-random stream spanning many laps of the ring.
        for (int i = 0; i < 400; i++) begin
            lfsr_step();
            step(lfsr[0] | lfsr[5], lfsr[IW+2:3], "R1");
        end
        // R3: reset in mid-traffic leaves stale valid slots behind.
        for (int i = 0; i < 8; i++) step(1'b1, IW'(i), "R1");
        do_reset();
        for (int i = 0; i < 200; i++) begin
            lfsr_step();
            step(lfsr[2], lfsr[IW+5:6], "R6");
        end
        // R2: drain with idle cycles only.
        for (int i = 0; i < 2 * D; i++) step(1'b0, '0, "R2");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        wait (edges > 20000 || done);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual edges=%0d expected below 20000", edges);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule